// File: doc/BRIEF.md
# Delay-Line Calibration and Phase Tuning Sequencer

This block sets up a receive-clock delay line on its own and then picks a sampling phase for it. It works in two steps. In the first step it calibrates: it sweeps the per-cell delay unit upward from zero. At each step it programs the line to measure its total length with the tap select one past the last cell. It stops at the first unit that returns a usable length. The index of the highest set bit of that length gives the largest phase the line can reach.

In the second step it tunes. It programs every phase from zero up to that maximum and asks an external tuning-test port whether the card answered correctly at that phase. It finds the longest unbroken run of passing phases and programs the phase at the middle of that run.

The delay line is reached through a 32-bit configuration word with a write strobe, two control bits and a 32-bit status word. The test port uses a request/acknowledge handshake. A single-cycle `done` or `err` pulse ends every sequence that `start` launches.

Top module: `dlcal_tuner`

## Requirements
- R1: After reset, `dl_cfg`, `dl_ctl`, `dl_wr`, `probe_req`, `done` and `err` are all zero.
- R2: Calibration starts at unit 0 and steps by one. Each unit gets one `dl_wr` strobe with these values:
  - `dl_ctl` = 2'b11 (bit 0 delay enable, bit 1 sampler enable).
  - Tap field (`dl_cfg[3:0]`) = NB_CELLS+1, which is 12 by default.
  - Unit field (`dl_cfg[14:8]`) = the unit being tried.
- R3: If the valid flag (`dl_stat[31]`) has not arrived within PRESC×TMO_TICKS clock cycles of a calibration write, the unit is skipped and the sweep moves to the next unit.
- R4: A length (`dl_stat[27:16]`) is accepted only when it is nonzero and below 2^NB_CELLS. A rejected length moves the sweep to the next unit. The first accepted unit ends calibration, and the unit field keeps that value to the end.
- R5: The maximum phase is the bit index of the highest set bit of the accepted length. Exactly maximum+1 probes follow.
- R6: If no unit up to UNIT_MAX is accepted, `err` pulses, no probe is made and `dl_ctl` returns to 2'b00.
- R7: Phases are probed in order 0, 1, …, maximum. Each phase is first written with `dl_ctl` = 2'b11 and tap = phase. The sampler enable is then cleared, so `dl_ctl` = 2'b01 while `probe_req` is high. `probe_req` stays high until `probe_ack`, and `probe_pass` is sampled with `probe_ack`.
- R8: A failed probe resets the current run. The best run is replaced only by a strictly longer run, so the first of two equal longest runs wins.
- R9: The final tap written is the end phase of the best run minus floor(best length / 2). `done` then pulses with `dl_ctl` = 2'b01, and `done` and `err` are never high together.
- R10: If no phase passes, `err` pulses instead of `done` and `dl_ctl` returns to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a sequence (taken when idle) |
| dl_cfg | output | 32 | Delay-line configuration word: tap [3:0], unit [14:8] |
| dl_ctl | output | 2 | Bit 0 delay enable, bit 1 sampler enable |
| dl_wr | output | 1 | One-cycle strobe when `dl_cfg` is written |
| dl_stat | input | 32 | Delay-line status: length [27:16], valid [31] |
| probe_req | output | 1 | Request a tuning test at the current tap |
| probe_ack | input | 1 | Test result is present |
| probe_pass | input | 1 | Test result, valid with `probe_ack` |
| done | output | 1 | One-cycle pulse: tuning finished |
| err | output | 1 | One-cycle pulse: calibration or tuning failed |

## Verification
The `dl_wr` strobe of a calibration write appears one cycle after its state is entered. The bench stub samples it on the falling edge of that same cycle and checks the unit order and field values there. While `probe_req` is high it checks the probed tap and the control bits on each falling edge, and it answers one cycle later. The `done` or `err` pulse comes one cycle after the final write, or one cycle after the last probe or timeout on failure. The bench therefore polls on falling edges until it sees the pulse. It then checks tap, unit, control bits, probe count and calibration-write count in that same half cycle. The expected values come from the bench's own sweep of the stub's per-unit table and its pass mask.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;
   localparam int WORD_W   = 32;
   localparam int TAP_LSB  = 0;
   localparam int TAP_W    = 4;
   localparam int UNIT_LSB = 8;
   localparam int UNIT_W   = 7;
   localparam int LEN_LSB  = 16;
   localparam int LEN_W    = 12;
   localparam int VLD_BIT  = 31;
   localparam int CTL_W    = 2;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CAL_WR,
      S_CAL_WAIT,
      S_PH_WR,
      S_PH_REL,
      S_PH_TEST,
      S_PH_EVAL,
      S_FIN_REL
   } seq_state_e;

   function automatic logic [TAP_W-1:0] top_bit(input logic [LEN_W-1:0] v);
      logic [TAP_W-1:0] r;
      r = '0;
      for (int i = 0; i < LEN_W; i++) begin
         if (v[i]) r = TAP_W'(i);
      end
      return r;
   endfunction
endpackage

// File: rtl/dlcal_timer.sv
module dlcal_timer #(
   parameter int PRESC = 100,
   parameter int TICKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expired
);
   localparam int TW = $clog2(TICKS + 1);

   logic          tick;
   logic [TW-1:0] cnt;

   if (PRESC < 1) begin : g_bad_presc
      $error("PRESC must be at least 1");
   end

   generate
      if (PRESC == 1) begin : g_direct
         assign tick = run;
      end else begin : g_div
         localparam int PW = $clog2(PRESC);
         logic [PW-1:0] pc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pc <= '0;
            else if (clr)   pc <= '0;
            else if (run)   pc <= (pc == PW'(PRESC - 1)) ? '0 : pc + PW'(1);
         end
         assign tick = run && (pc == PW'(PRESC - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (clr)                        cnt <= '0;
      else if (tick && cnt != TW'(TICKS))  cnt <= cnt + TW'(1);
   end

   assign expired = (cnt == TW'(TICKS));
endmodule

// File: rtl/dlcal_window.sv
module dlcal_window #(
   parameter int PH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            upd,
   input  logic            pass,
   input  logic [PH_W-1:0] phase,
   output logic [PH_W:0]   best_len,
   output logic [PH_W-1:0] best_end
);
   logic [PH_W:0] cur_len;
   logic [PH_W:0] cur_nxt;

   assign cur_nxt = cur_len + (PH_W+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_len  <= '0;
         best_len <= '0;
         best_end <= '0;
      end else if (clr) begin
         cur_len  <= '0;
         best_len <= '0;
         best_end <= '0;
      end else if (upd) begin
         if (!pass) begin
            cur_len <= '0;
         end else begin
            cur_len <= cur_nxt;
            if (cur_nxt > best_len) begin
               best_len <= cur_nxt;
               best_end <= phase;
            end
         end
      end
   end
endmodule

// File: rtl/dlcal_tuner.sv
module dlcal_tuner
   import dlcal_pkg::*;
#(
   parameter int NB_CELLS  = 11,
   parameter int UNIT_MAX  = 127,
   parameter int PRESC     = 100,
   parameter int TMO_TICKS = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [WORD_W-1:0] dl_cfg,
   output logic [CTL_W-1:0]  dl_ctl,
   output logic              dl_wr,
   input  logic [WORD_W-1:0] dl_stat,
   output logic              probe_req,
   input  logic              probe_ack,
   input  logic              probe_pass,
   output logic              done,
   output logic              err
);
   localparam int CAL_TAP = NB_CELLS + 1;
   localparam int LEN_LIM = 1 << NB_CELLS;
   localparam logic [WORD_W-1:0] FIELD_MASK =
      (((WORD_W)'(1) << LEN_W) - 1) << LEN_LSB | (WORD_W)'(1) << VLD_BIT;

   if (CAL_TAP >= (1 << TAP_W)) begin : g_bad_tap
      $error("NB_CELLS+1 does not fit the tap field");
   end
   if (UNIT_MAX >= (1 << UNIT_W)) begin : g_bad_unit
      $error("UNIT_MAX does not fit the unit field");
   end
   if (NB_CELLS >= LEN_W) begin : g_bad_len
      $error("NB_CELLS must be below the length width");
   end

   seq_state_e        st;
   logic [UNIT_W-1:0] unit_q;
   logic [TAP_W-1:0]  tap_q;
   logic [TAP_W-1:0]  max_q;
   logic [TAP_W-1:0]  ph_q;
   logic              en_q, smp_q, wr_q, req_q, done_q, err_q;

   logic [LEN_W-1:0]  len_in;
   logic              vld_in, len_ok, seen, accept, give_up, expired;
   logic [TAP_W:0]    best_len;
   logic [TAP_W-1:0]  best_end;
   logic              stat_unused;

   assign len_in      = dl_stat[LEN_LSB +: LEN_W];
   assign vld_in      = dl_stat[VLD_BIT];
   assign stat_unused = ^(dl_stat & ~FIELD_MASK);
   assign len_ok      = (len_in != '0) && (len_in < LEN_W'(LEN_LIM));
   assign seen        = vld_in && !wr_q;
   assign accept      = seen && len_ok;
   assign give_up     = (seen && !len_ok) || (!seen && expired);

   dlcal_timer #(.PRESC(PRESC), .TICKS(TMO_TICKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (st == S_CAL_WR),
      .run     (st == S_CAL_WAIT),
      .expired (expired)
   );

   dlcal_window #(.PH_W(TAP_W)) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (st == S_CAL_WR),
      .upd      ((st == S_PH_TEST) && probe_ack),
      .pass     (probe_pass),
      .phase    (ph_q),
      .best_len (best_len),
      .best_end (best_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         unit_q <= '0;
         tap_q  <= '0;
         max_q  <= '0;
         ph_q   <= '0;
         en_q   <= 1'b0;
         smp_q  <= 1'b0;
         wr_q   <= 1'b0;
         req_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         wr_q   <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st)
            S_IDLE: begin
               if (start) begin
                  unit_q <= '0;
                  st     <= S_CAL_WR;
               end
            end
            S_CAL_WR: begin
               en_q  <= 1'b1;
               smp_q <= 1'b1;
               tap_q <= TAP_W'(CAL_TAP);
               wr_q  <= 1'b1;
               st    <= S_CAL_WAIT;
            end
            S_CAL_WAIT: begin
               if (accept) begin
                  max_q <= top_bit(len_in);
                  ph_q  <= '0;
                  st    <= S_PH_WR;
               end else if (give_up) begin
                  if (unit_q == UNIT_W'(UNIT_MAX)) begin
                     err_q <= 1'b1;
                     en_q  <= 1'b0;
                     smp_q <= 1'b0;
                     st    <= S_IDLE;
                  end else begin
                     unit_q <= unit_q + UNIT_W'(1);
                     st     <= S_CAL_WR;
                  end
               end
            end
            S_PH_WR: begin
               en_q  <= 1'b1;
               smp_q <= 1'b1;
               tap_q <= ph_q;
               wr_q  <= 1'b1;
               st    <= S_PH_REL;
            end
            S_PH_REL: begin
               smp_q <= 1'b0;
               req_q <= 1'b1;
               st    <= S_PH_TEST;
            end
            S_PH_TEST: begin
               if (probe_ack) begin
                  req_q <= 1'b0;
                  if (ph_q == max_q) begin
                     st <= S_PH_EVAL;
                  end else begin
                     ph_q <= ph_q + TAP_W'(1);
                     st   <= S_PH_WR;
                  end
               end
            end
            S_PH_EVAL: begin
               if (best_len == '0) begin
                  err_q <= 1'b1;
                  en_q  <= 1'b0;
                  smp_q <= 1'b0;
                  st    <= S_IDLE;
               end else begin
                  tap_q <= best_end - TAP_W'(best_len >> 1);
                  smp_q <= 1'b1;
                  wr_q  <= 1'b1;
                  st    <= S_FIN_REL;
               end
            end
            S_FIN_REL: begin
               smp_q  <= 1'b0;
               done_q <= 1'b1;
               st     <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      dl_cfg = '0;
      dl_cfg[TAP_LSB +: TAP_W]   = tap_q;
      dl_cfg[UNIT_LSB +: UNIT_W] = unit_q;
   end

   assign dl_ctl    = {smp_q, en_q};
   assign dl_wr     = wr_q;
   assign probe_req = req_q;
   assign done      = done_q;
   assign err       = err_q;
endmodule

// File: rtl/dlcal_tuner_chk.sv
module dlcal_tuner_chk #(
   parameter int TAP_W   = 4,
   parameter int UNIT_W  = 7,
   parameter int CAL_TAP = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_wait,
   input logic              accept,
   input logic              expired,
   input logic              dl_wr,
   input logic [1:0]        dl_ctl,
   input logic [TAP_W-1:0]  tap,
   input logic [UNIT_W-1:0] unit,
   input logic [TAP_W-1:0]  max_ph,
   input logic              probe_req,
   input logic              probe_ack,
   input logic              done,
   input logic              err
);
   p_cal_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && dl_wr) |-> (tap == TAP_W'(CAL_TAP) && dl_ctl == 2'b11));

   p_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && expired && !accept) |=> !in_wait);

   p_unit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wait && $past(in_wait)) |-> $stable(unit));

   p_probe_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      probe_req |-> (tap <= max_ph));

   p_err_ctl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (dl_ctl == 2'b00));

   p_sen_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      probe_req |-> (dl_ctl == 2'b01));

   p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_req && !probe_ack) |=> probe_req);

   p_done_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (dl_ctl == 2'b01 && !err));
endmodule

bind dlcal_tuner dlcal_tuner_chk #(
   .TAP_W   (dlcal_pkg::TAP_W),
   .UNIT_W  (dlcal_pkg::UNIT_W),
   .CAL_TAP (NB_CELLS + 1)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_wait   (st == dlcal_pkg::S_CAL_WAIT),
   .accept    (accept),
   .expired   (expired),
   .dl_wr     (dl_wr),
   .dl_ctl    (dl_ctl),
   .tap       (tap_q),
   .unit      (unit_q),
   .max_ph    (max_q),
   .probe_req (probe_req),
   .probe_ack (probe_ack),
   .done      (done),
   .err       (err)
);

// File: tb/dlcal_tuner_tb_top.sv
module dlcal_tuner_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int PRESC      = 2;
   localparam int TMO_TICKS  = 5;
   localparam int NB_UNITS   = 128;
   localparam int WD_LIMIT   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dl_cfg;
   logic [1:0]  dl_ctl;
   logic        dl_wr;
   logic        probe_req;
   logic        probe_ack = 1'b0;
   logic        probe_pass = 1'b0;
   logic        done, err;
   logic        st_vld = 1'b0;
   logic [11:0] st_len = '0;

   int          kind [NB_UNITS];
   int          rdly [NB_UNITS];
   logic [11:0] rlen [NB_UNITS];
   logic [15:0] mask;

   int n_chk = 0, n_fail = 0;
   int cal_wr_n = 0, probe_n = 0, cd = -1;
   logic [11:0] cur_len = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dlcal_tuner #(.PRESC(PRESC), .TMO_TICKS(TMO_TICKS)) dut_i (
      .clk (clk), .rst_n (rst_n), .start (start),
      .dl_cfg (dl_cfg), .dl_ctl (dl_ctl), .dl_wr (dl_wr),
      .dl_stat ({st_vld, 3'b000, st_len, 16'h0000}),
      .probe_req (probe_req), .probe_ack (probe_ack), .probe_pass (probe_pass),
      .done (done), .err (err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // behavioural delay line and tuning-test responder
   always @(negedge clk) begin
      if (probe_ack) begin
         probe_ack = 1'b0;
      end else if (probe_req) begin
         chk(int'(dl_cfg[3:0]) == probe_n, "R7", "probed tap order", dl_cfg[3:0], probe_n);
         chk(dl_ctl == 2'b01, "R7", "ctl during probe", dl_ctl, 1);
         probe_pass = mask[dl_cfg[3:0]];
         probe_ack  = 1'b1;
         probe_n++;
      end
      if (dl_wr) begin
         st_vld = 1'b0;
         cd     = -1;
         if (dl_ctl == 2'b11 && dl_cfg[3:0] == 4'd12) begin
            chk(int'(dl_cfg[14:8]) == cal_wr_n, "R2", "unit order", dl_cfg[14:8], cal_wr_n);
            chk(dl_cfg[31:15] == '0 && dl_cfg[7:4] == '0, "R2", "spare cfg bits", 0, 0);
            if (kind[dl_cfg[14:8]] != 0) cd = rdly[dl_cfg[14:8]];
            cur_len = rlen[dl_cfg[14:8]];
            cal_wr_n++;
         end
      end else if (cd > 0) begin
         cd--;
         if (cd == 0) begin
            st_vld = 1'b1;
            st_len = cur_len;
         end
      end
   end

   function automatic int msb_of(input int v);
      int r = 0;
      for (int i = 0; i < 12; i++) if (v[i]) r = i;
      return r;
   endfunction

   task automatic clear_units();
      for (int u = 0; u < NB_UNITS; u++) begin
         kind[u] = 0; rdly[u] = 1; rlen[u] = '0;
      end
   endtask

   task automatic set_unit(input int u, input int d, input int len);
      kind[u] = 1; rdly[u] = d; rlen[u] = 12'(len);
   endtask

   task automatic run_case(input string nm);
      int eu, mx, best, bend, cur, cyc, exp_tap, exp_probes;
      bit cal_ok, tune_ok;
      eu = -1;
      // timely reply: well inside PRESC*TMO_TICKS cycles
      for (int u = 0; u < NB_UNITS; u++) begin
         if (eu < 0 && kind[u] != 0 && rdly[u] < PRESC*TMO_TICKS - 2 &&
             rlen[u] != 0 && rlen[u] < 12'd2048) eu = u;
      end
      cal_ok = (eu >= 0);
      mx = cal_ok ? msb_of(int'(rlen[eu])) : 0;
      best = 0; bend = 0; cur = 0;
      if (cal_ok) begin
         for (int p = 0; p <= mx; p++) begin
            if (mask[p]) begin
               cur++;
               if (cur > best) begin best = cur; bend = p; end
            end else cur = 0;
         end
      end
      tune_ok    = cal_ok && best > 0;
      exp_tap    = bend - best / 2;
      exp_probes = cal_ok ? mx + 1 : 0;

      cal_wr_n = 0; probe_n = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      cyc = 0;
      while (!(done || err) && cyc < WD_LIMIT) begin
         @(negedge clk);
         cyc++;
      end
      if (cyc >= WD_LIMIT) begin
         chk(1'b0, "R9", {nm, " watchdog"}, cyc, WD_LIMIT);
      end else begin
         chk(done == tune_ok, tune_ok ? "R9" : (cal_ok ? "R10" : "R6"),
             {nm, " done"}, done, tune_ok);
         chk(err == !tune_ok, cal_ok ? "R10" : "R6", {nm, " err"}, err, !tune_ok);
         chk(probe_n == exp_probes, "R5", {nm, " probe count"}, probe_n, exp_probes);
         if (cal_ok) begin
            chk(cal_wr_n == eu + 1, "R4", {nm, " cal writes"}, cal_wr_n, eu + 1);
            chk(int'(dl_cfg[14:8]) == eu, "R4", {nm, " unit kept"}, dl_cfg[14:8], eu);
         end else begin
            chk(cal_wr_n == NB_UNITS, "R6", {nm, " cal writes"}, cal_wr_n, NB_UNITS);
         end
         if (tune_ok) begin
            chk(int'(dl_cfg[3:0]) == exp_tap, "R8", {nm, " final tap"}, dl_cfg[3:0], exp_tap);
            chk(dl_ctl == 2'b01, "R9", {nm, " ctl at done"}, dl_ctl, 1);
         end else begin
            chk(dl_ctl == 2'b00, cal_ok ? "R10" : "R6", {nm, " ctl at err"}, dl_ctl, 0);
         end
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      clear_units();
      mask = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(dl_cfg == '0 && dl_ctl == '0 && !dl_wr && !probe_req && !done && !err,
          "R1", "outputs in reset", int'(dl_cfg), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dl_cfg == '0 && dl_ctl == '0 && !dl_wr && !probe_req && !done && !err,
          "R1", "outputs after reset", int'(dl_ctl), 0);

      // R5 R8: first unit accepted, max phase 6, single window
      clear_units(); set_unit(0, 2, 12'h07F); mask = 16'b0000_0000_0001_1100;
      run_case("single");

      // R3 R4: timeout, late reply, zero and oversized lengths skipped; R8 tie
      clear_units(); set_unit(1, 25, 12'h400); set_unit(2, 1, 0);
      set_unit(3, 2, 12'h800); set_unit(4, 3, 12'h400);
      mask = 16'b0000_0001_1100_1110;
      run_case("skips");

      // R5: length 1 gives a single phase 0
      clear_units();
      for (int u = 0; u < 5; u++) set_unit(u, 1, 12'hFFF);
      set_unit(5, 1, 1); mask = 16'h0001;
      run_case("max0");

      // R6: no unit accepted across the whole sweep
      clear_units();
      for (int u = 0; u < NB_UNITS; u += 2) set_unit(u, 1, (u % 4 == 0) ? 0 : 12'hC00);
      mask = 16'hFFFF;
      run_case("nocal");

      // R10: no passing phase
      clear_units(); set_unit(0, 1, 3); mask = 16'h0000;
      run_case("nopass");

      // R9: every phase passes
      clear_units(); set_unit(0, 1, 12'h155); mask = 16'hFFFF;
      run_case("allpass");

      // R8: equal runs, earlier one kept
      clear_units(); set_unit(0, 2, 12'h5A5); mask = 16'b0000_0111_0111_0101;
      run_case("tie");

      // R8: longer run later replaces earlier one
      clear_units(); set_unit(0, 1, 12'h020); mask = 16'b0000_0000_0011_1011;
      run_case("later");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule